// File: doc/BRIEF.md
# Word-Organized Core Memory Access Sequencer

This block controls the timing of every access to a small word-organized magnetic core store. A requester presents a read or write command with a word address and, for writes, a data word. The sequencer divides the address into a row number and a column number and decodes each one to a one-hot gate select. It then runs a fixed program: setup, destructive read, sense capture, gate guard, write setup, write-back, done.

Every access reads first. During the read drive pulse the sense amplifiers present the stored word, and the block captures it into a data register at the end of the read phase. The write phase then stores one of two words. A write command stores the new input word. A read command stores back the word just captured. The column decoder output goes to the read-gate set during the read phase and to the write-gate set during the write phase, and the two sets are never on together. Between the two phases a guard interval gives the read gate time to turn off before any write current flows.

All phase lengths are given in nanoseconds. They are turned into clock ticks at elaboration from the clock period, rounding up. With the default settings the whole access takes 35 ticks of 100 ns, which is inside the 4 µs budget.

Top module: `core_seq`

## Requirements
- R1: A valid address `a` (0 to 99) selects row gate `a / 10` and column gate `a % 10`. Each of these is a one-hot 10-bit vector, and line `k` drives bit `k`.
- R2: The selected row gate is asserted from the first setup tick through the last write-drive tick, without a break. It is zero at all other times.
- R3: The column select drives `col_rd_gate_o` only during the read setup, read drive and strobe phases. It drives `col_wr_gate_o` only during the write setup and write drive phases. The two are never nonzero in the same cycle.
- R4: The read drive is high for exactly ceil(READ_NS/CLK_NS) consecutive cycles per valid access.
- R5: Each drive pulse starts only after its row and column gates have been on for at least ceil(GATE_NS/CLK_NS) cycles.
- R6: After the read gate turns off, at least ceil(FALL_NS/CLK_NS) cycles pass before the write drive starts. The write drive lasts ceil(WRITE_NS/CLK_NS) cycles.
- R7: `strobe_o` is high for one cycle, right after the read drive ends. `sense_i` is captured at the end of that cycle and appears on `rdata_o` from the next cycle on.
- R8: During the write drive, help bit `i` is high exactly when bit `i` of the word being stored is 1. A write command stores `wdata_i`, and a read command stores the captured word. At all other times `help_o` is zero.
- R9: From acceptance to the `done_o` pulse, a valid access takes at most CYCLE_NS/CLK_NS cycles.
- R10: A request is accepted only when `busy_o` is low. A request made while busy has no effect on the stored words or on the outputs.
- R11: An address from 100 to 127 drives no gate and no drive line. The next cycle it gives a single-cycle `done_o` and sets `err_o`. `err_o` stays set until the next valid request is accepted.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled while idle |
| wr_i | input | 1 | 1 = write command, 0 = read command |
| addr_i | input | 7 | Word address |
| wdata_i | input | 20 | Word to store on a write command |
| sense_i | input | 20 | Sense amplifier outputs |
| busy_o | output | 1 | High from acceptance through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Address out of range, held until the next valid request |
| rdata_o | output | 20 | Word captured during the last read phase |
| row_gate_o | output | 10 | One-hot row gate enables |
| col_rd_gate_o | output | 10 | One-hot column read-gate enables |
| col_wr_gate_o | output | 10 | One-hot column write-gate enables |
| rd_drive_o | output | 1 | Read drive current enable |
| wr_drive_o | output | 1 | Write drive current enable |
| strobe_o | output | 1 | Sense amplifier latch strobe |
| help_o | output | 20 | Per-bit help line enables |

## Verification
The bench drives `sense_i` with the stored word only in the strobe cycle and with a junk pattern at all other times. A design that samples one cycle early or one cycle late therefore returns the junk pattern and writes it back, and a later read of the same address exposes the error. Accesses to addresses 0, 45 and 99 check both ends of the row and column split. A read of a freshly written word confirms that write data, not the old contents, reaches the help lines. A request issued in the middle of a cycle must leave the target word unchanged; a design that latches it would corrupt that word or its timing. Addresses 100 and 127 must leave every gate low and hold the error flag until a valid request clears it; a design that decodes them would pulse a gate line.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_RDRV  = 3'd2,
        PH_STRB  = 3'd3,
        PH_GUARD = 3'd4,
        PH_WSET  = 3'd5,
        PH_WDRV  = 3'd6,
        PH_DONE  = 3'd7
    } phase_e;

    // Duration in ns to whole clock ticks, rounded up
    function automatic int ns_to_ticks(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/core_seq_decode.sv
module core_seq_decode #(
    parameter int N  = 10,
    parameter int IW = $clog2(N)
) (
    input  logic [IW-1:0] idx_i,
    output logic [N-1:0]  sel_o
);
    for (genvar k = 0; k < N; k++) begin : g_line
        assign sel_o[k] = (idx_i == IW'(k));
    end
endmodule

// File: rtl/core_seq_ctrl.sv
module core_seq_ctrl
    import core_seq_pkg::*;
#(
    parameter int T_GATE = 2,
    parameter int T_RD   = 14,
    parameter int T_FALL = 5,
    parameter int T_WR   = 10
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   bad_i,
    output phase_e phase_o
);
    localparam int TMAX = (T_RD > T_WR) ? ((T_RD > T_FALL) ? T_RD : T_FALL)
                                        : ((T_WR > T_FALL) ? T_WR : T_FALL);
    localparam int CW   = $clog2(TMAX + T_GATE + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t s_d, s_q;

    function automatic logic [CW-1:0] span(input phase_e p);
        case (p)
            PH_SETUP, PH_WSET: return CW'(T_GATE - 1);
            PH_RDRV:           return CW'(T_RD - 1);
            PH_GUARD:          return CW'(T_FALL - 1);
            PH_WDRV:           return CW'(T_WR - 1);
            default:           return '0;
        endcase
    endfunction

    function automatic phase_e after(input phase_e p);
        case (p)
            PH_SETUP: return PH_RDRV;
            PH_RDRV:  return PH_STRB;
            PH_STRB:  return PH_GUARD;
            PH_GUARD: return PH_WSET;
            PH_WSET:  return PH_WDRV;
            PH_WDRV:  return PH_DONE;
            default:  return PH_IDLE;
        endcase
    endfunction

    always_comb begin
        s_d = s_q;
        if (s_q.ph == PH_IDLE) begin
            if (start_i) begin
                s_d.ph  = bad_i ? PH_DONE : PH_SETUP;
                s_d.cnt = bad_i ? '0 : span(PH_SETUP);
            end
        end else if (s_q.cnt == '0) begin
            s_d.ph  = after(s_q.ph);
            s_d.cnt = span(after(s_q.ph));
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase_o = s_q.ph;
endmodule

// File: rtl/core_seq.sv
module core_seq
    import core_seq_pkg::*;
#(
    parameter int ROWS     = 10,
    parameter int COLS     = 10,
    parameter int WIDTH    = 20,
    parameter int ADDR_W   = 7,
    parameter int CLK_NS   = 100,
    parameter int GATE_NS  = 200,
    parameter int READ_NS  = 1400,
    parameter int FALL_NS  = 500,
    parameter int WRITE_NS = 1000,
    parameter int CYCLE_NS = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  sense_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [WIDTH-1:0]  rdata_o,
    output logic [ROWS-1:0]   row_gate_o,
    output logic [COLS-1:0]   col_rd_gate_o,
    output logic [COLS-1:0]   col_wr_gate_o,
    output logic              rd_drive_o,
    output logic              wr_drive_o,
    output logic              strobe_o,
    output logic [WIDTH-1:0]  help_o
);
    localparam int DEPTH  = ROWS * COLS;
    localparam int RW     = $clog2(ROWS);
    localparam int CWI    = $clog2(COLS);
    localparam int T_GATE = ns_to_ticks(GATE_NS, CLK_NS);
    localparam int T_RD   = ns_to_ticks(READ_NS, CLK_NS);
    localparam int T_FALL = ns_to_ticks(FALL_NS, CLK_NS);
    localparam int T_WR   = ns_to_ticks(WRITE_NS, CLK_NS);

    typedef struct packed {
        logic [ROWS-1:0]  row_sel;
        logic [COLS-1:0]  col_sel;
        logic             wr;
        logic [WIDTH-1:0] wbuf;
        logic [WIDTH-1:0] data;
        logic             err;
    } dp_t;

    dp_t    s_d, s_q;
    phase_e phase;
    logic   accept, addr_ok;
    logic [RW-1:0]   row_idx;
    logic [CWI-1:0]  col_idx;
    logic [ROWS-1:0] row_dec;
    logic [COLS-1:0] col_dec;

    assign addr_ok = (32'(addr_i) < DEPTH);
    assign accept  = req_i && (phase == PH_IDLE);
    assign row_idx = RW'(32'(addr_i) / COLS);
    assign col_idx = CWI'(32'(addr_i) % COLS);

    core_seq_decode #(.N(ROWS), .IW(RW)) u_row_dec (.idx_i(row_idx), .sel_o(row_dec));
    core_seq_decode #(.N(COLS), .IW(CWI)) u_col_dec (.idx_i(col_idx), .sel_o(col_dec));

    core_seq_ctrl #(
        .T_GATE(T_GATE), .T_RD(T_RD), .T_FALL(T_FALL), .T_WR(T_WR)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(accept), .bad_i(!addr_ok), .phase_o(phase)
    );

    always_comb begin
        s_d = s_q;
        if (accept) begin
            s_d.err     = !addr_ok;
            s_d.row_sel = addr_ok ? row_dec : '0;
            s_d.col_sel = addr_ok ? col_dec : '0;
            s_d.wr      = wr_i;
            s_d.wbuf    = wdata_i;
        end
        if (phase == PH_STRB) s_d.data = sense_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic in_read, in_write, in_cycle;
    assign in_read  = (phase == PH_SETUP) || (phase == PH_RDRV) || (phase == PH_STRB);
    assign in_write = (phase == PH_WSET) || (phase == PH_WDRV);
    assign in_cycle = in_read || in_write || (phase == PH_GUARD);

    assign busy_o        = (phase != PH_IDLE);
    assign done_o        = (phase == PH_DONE);
    assign err_o         = s_q.err;
    assign rdata_o       = s_q.data;
    assign row_gate_o    = in_cycle ? s_q.row_sel : '0;
    assign col_rd_gate_o = in_read  ? s_q.col_sel : '0;
    assign col_wr_gate_o = in_write ? s_q.col_sel : '0;
    assign rd_drive_o    = (phase == PH_RDRV);
    assign wr_drive_o    = (phase == PH_WDRV);
    assign strobe_o      = (phase == PH_STRB);
    assign help_o        = (phase == PH_WDRV) ? (s_q.wr ? s_q.wbuf : s_q.data) : '0;
endmodule

// File: rtl/core_seq_chk.sv
module core_seq_chk #(
    parameter int ROWS     = 10,
    parameter int COLS     = 10,
    parameter int WIDTH    = 20,
    parameter int CLK_NS   = 100,
    parameter int GATE_NS  = 200,
    parameter int FALL_NS  = 500,
    parameter int CYCLE_NS = 4000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             err_o,
    input logic [ROWS-1:0]  row_gate_o,
    input logic [COLS-1:0]  col_rd_gate_o,
    input logic [COLS-1:0]  col_wr_gate_o,
    input logic             rd_drive_o,
    input logic             wr_drive_o,
    input logic [WIDTH-1:0] help_o
);
    localparam int TG = (GATE_NS + CLK_NS - 1) / CLK_NS;
    localparam int TF = (FALL_NS + CLK_NS - 1) / CLK_NS;
    localparam int TB = CYCLE_NS / CLK_NS;

    logic [15:0] rd_on_cnt, wr_on_cnt, off_cnt, busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_on_cnt <= '0;
            wr_on_cnt <= '0;
            off_cnt   <= '0;
            busy_cnt  <= '0;
        end else begin
            rd_on_cnt <= (|row_gate_o && |col_rd_gate_o) ? rd_on_cnt + 16'd1 : '0;
            wr_on_cnt <= (|row_gate_o && |col_wr_gate_o) ? wr_on_cnt + 16'd1 : '0;
            off_cnt   <= (|col_rd_gate_o) ? '0 : ((off_cnt == 16'hFFFF) ? off_cnt : off_cnt + 16'd1);
            busy_cnt  <= busy_o ? busy_cnt + 16'd1 : '0;
        end
    end

    p_row_during_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive_o || wr_drive_o) |-> $onehot(row_gate_o));

    p_one_col_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|col_rd_gate_o && |col_wr_gate_o));

    p_col_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_rd_gate_o | col_wr_gate_o));

    p_rd_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_drive_o) |-> (32'(rd_on_cnt) >= TG));

    p_wr_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_drive_o) |-> (32'(wr_on_cnt) >= TG));

    p_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_drive_o) |-> (32'(off_cnt) >= TF));

    p_help_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|help_o) |-> wr_drive_o);

    p_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (32'(busy_cnt) < TB));

    p_err_no_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (row_gate_o == '0 && !rd_drive_o && !wr_drive_o));
endmodule

bind core_seq core_seq_chk #(
    .ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .CLK_NS(CLK_NS),
    .GATE_NS(GATE_NS), .FALL_NS(FALL_NS), .CYCLE_NS(CYCLE_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .err_o(err_o),
    .row_gate_o(row_gate_o), .col_rd_gate_o(col_rd_gate_o),
    .col_wr_gate_o(col_wr_gate_o), .rd_drive_o(rd_drive_o),
    .wr_drive_o(wr_drive_o), .help_o(help_o)
);

// File: tb/core_seq_tb_top.sv
module core_seq_tb_top;
    localparam int CLK = 20;
    localparam int G = (200 + CLK - 1) / CLK;
    localparam int R = (1400 + CLK - 1) / CLK;
    localparam int F = (500 + CLK - 1) / CLK;
    localparam int W = (1000 + CLK - 1) / CLK;
    localparam int P_STRB = G + R;
    localparam int P_WSET = P_STRB + 1 + F;
    localparam int P_WDRV = P_WSET + G;
    localparam int P_DONE = P_WDRV + W;
    localparam logic [19:0] JUNK = 20'hC3A5F;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0;
    logic [6:0]  addr = '0;
    logic [19:0] wdata = '0, sense;
    logic busy, done, err, rd_drv, wr_drv, strobe;
    logic [19:0] rdata, help;
    logic [9:0]  row_g, crd_g, cwr_g;

    int tests = 0, fails = 0, cyc = 0;

    // behavioural model state
    logic [19:0] mem [100];
    bit    m_act = 0, m_bad = 0, m_wr = 0, m_err = 0;
    int    m_p = 0, m_a = 0, m_busy_len = 0;
    logic [19:0] m_wd = '0, m_rdata = '0, m_old = '0;

    always #(CLK/2) clk = ~clk;

    assign sense = strobe ? mem[m_a] : JUNK;

    core_seq #(.CLK_NS(CLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .sense_i(sense), .busy_o(busy), .done_o(done),
        .err_o(err), .rdata_o(rdata), .row_gate_o(row_g), .col_rd_gate_o(crd_g),
        .col_wr_gate_o(cwr_g), .rd_drive_o(rd_drv), .wr_drive_o(wr_drv),
        .strobe_o(strobe), .help_o(help)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // model advance
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_act = 0; m_err = 0; m_rdata = '0; m_p = 0;
        end else if (m_act) begin
            if (!m_bad && m_p == P_STRB) m_rdata = m_old;
            if (m_bad ? 1'b1 : (m_p == P_DONE)) begin
                if (!m_bad) mem[m_a] = m_wr ? m_wd : m_old;
                m_act = 0;
            end
            m_p++;
        end else if (req) begin
            m_act = 1; m_p = 0;
            m_bad = (addr >= 7'd100);
            m_err = m_bad;
            if (!m_bad) begin
                m_a = int'(addr); m_wr = wr; m_wd = wdata; m_old = mem[m_a];
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin : cmp
            bit v, rp, wp;
            logic [9:0] er, ec;
            v  = m_act && !m_bad;
            er = v ? (10'd1 << (m_a / 10)) : '0;
            ec = v ? (10'd1 << (m_a % 10)) : '0;
            rp = v && m_p < P_STRB + 1;
            wp = v && m_p >= P_WSET && m_p < P_DONE;
            chk("R10 busy", 32'(busy), 32'(m_act));
            chk("R11 done", 32'(done), 32'(m_act && (m_bad || m_p == P_DONE)));
            chk("R11 err", 32'(err), 32'(m_err));
            chk("R1 R2 row gate", 32'(row_g), 32'((v && m_p < P_DONE) ? er : 10'd0));
            chk("R3 col read gate", 32'(crd_g), 32'(rp ? ec : 10'd0));
            chk("R3 col write gate", 32'(cwr_g), 32'(wp ? ec : 10'd0));
            chk("R4 R5 read drive", 32'(rd_drv), 32'(v && m_p >= G && m_p < P_STRB));
            chk("R6 write drive", 32'(wr_drv), 32'(v && m_p >= P_WDRV && m_p < P_DONE));
            chk("R7 strobe", 32'(strobe), 32'(v && m_p == P_STRB));
            chk("R8 help", 32'(help),
                32'((v && m_p >= P_WDRV && m_p < P_DONE) ? (m_wr ? m_wd : m_old) : 20'd0));
            chk("R7 rdata", 32'(rdata), 32'(m_rdata));
            if (busy) m_busy_len++;
            if (done && !err) begin
                chk("R9 cycle length", 32'(m_busy_len * CLK <= 4000), 32'd1);
            end
            if (!busy) m_busy_len = 0;
        end
    end

    task automatic access(input bit w, input int a, input logic [19:0] d);
        @(negedge clk);
        req = 1'b1; wr = w; addr = 7'(a); wdata = d;
        @(negedge clk);
        req = 1'b0; wdata = 20'hFFFFF;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 100; i++) mem[i] = 20'((i * 32'h3A5C7) ^ 32'h5A5A5);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset outputs",
            32'({busy, done, err, rd_drv, wr_drv, strobe, |row_g, |crd_g, |cwr_g, |help, |rdata}), 32'd0);
        rst_n = 1'b1;
        access(0, 0, '0);
        access(1, 99, 20'hA0F35);
        access(0, 99, '0);
        chk("R8 write stored", 32'(rdata), 32'h000A0F35);
        access(1, 45, 20'h00001);
        access(0, 45, '0);
        chk("R1 mid address", 32'(rdata), 32'h00000001);
        // R10 request while busy
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 7'd10;
        @(negedge clk);
        req = 1'b0;
        repeat (40) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 7'd11; wdata = 20'h12345;
        @(negedge clk);
        req = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        access(0, 11, '0);
        chk("R10 busy request ignored", 32'(rdata), 32'(20'((11 * 32'h3A5C7) ^ 32'h5A5A5)));
        // R11 out of range
        access(1, 100, 20'h55555);
        chk("R11 err held", 32'(err), 32'd1);
        access(0, 127, '0);
        access(0, 10, '0);
        chk("R11 err cleared", 32'(err), 32'd0);
        access(0, 9, '0);
        access(0, 90, '0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        fails++; tests++;
        $display("FAIL R9 watchdog expired actual=%0d expected<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule